// File: doc/BRIEF.md
# Dual Reload Timer with Shared Interrupt

This block contains two down-counters that run independently and share one interrupt. Each counter has a reload value, a control word and a live count, and all of them sit in a 32-bit word-addressed register space. The control word selects the tick input that advances the counter. It also sets a command: the counter can be loaded from its reload value, frozen, or left free-running. A running counter is periodic. When its period ends, it refills itself from the reload value and raises its own bit in a shared status register.

The status register is masked, and the result drives one level-sensitive interrupt line. Software clears status bits by writing ones to an acknowledge word. The block makes no clocks of its own. Its tick inputs are single-cycle enable strobes from elsewhere in the chip: four fixed-rate strobes and one external strobe. The register port is a plain single-cycle access with no back-pressure. A write takes effect at the clock edge where `reg_en` and `reg_wr` are both high. Read data is combinational and is valid in the same cycle that `reg_en` is high with `reg_wr` low.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every readable register returns 0 and `irq` is low. The counters do not advance until a run command is written.
- R2: Word map (byte addresses): timer t has its reload value at 0x00+16t, its count at 0x04+16t and its control at 0x08+16t, for t = 0 and 1. Mask is at 0x48, acknowledge at 0x4C, raw status at 0x50 and masked status at 0x54. Reload and control read back the value last accepted, with control holding bits [4:0] only. Mask holds bits [1:0] only, and upper bits read 0.
- R3: Control bits [1:0] carry the command. Code 0 copies the reload value into the count and leaves the counter stopped. Code 1 keeps the count frozen whatever the tick inputs do.
- R4: Command code 2 runs the counter, and each cycle its chosen tick is high lowers the count by one. Control bits [4:2] choose the tick: 1 selects `tick_ext`, 4 to 7 select `tick_rate[0]` to `tick_rate[3]`, and 0, 2 and 3 select no tick. Ticks on other inputs have no effect.
- R5: A chosen tick that arrives while a running count is 0 or 1 refills the count from the reload value and sets status bit t (bit 0 for timer 0, bit 1 for timer 1), so a reload value of N gives a period of N ticks.
- R6: A write to the acknowledge word clears each status bit whose data bit is 1 and leaves the others unchanged. The acknowledge word always reads 0.
- R7: Masked status is raw status AND mask, and `irq` is high exactly when masked status is non-zero. A mask write or acknowledge write changes `irq` at the same edge that updates the register.
- R8: When an expiry and an acknowledge of the same status bit land on the same edge, the bit ends up set.
- R9: A reload-value write does not alter the count. The new value is used at the next load command or the next periodic refill.
- R10: A control write with command code 3 is ignored completely. Control and count keep their previous values.
- R11: Reads of unmapped addresses return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational, 0 when not reading |
| tick_rate | input | 4 | Fixed-rate tick strobes, selected by codes 4 to 7 |
| tick_ext | input | 1 | External tick strobe, selected by code 1 |
| irq | output | 1 | Level interrupt, high while any masked status bit is set |

## Verification
A counter that has stepped wrongly shows up in the count word in the cycle right after the bad tick edge. A refill from the wrong value does not show until its consequence appears: the count read back differs, and the next status bit and `irq` come one period early or late. A wrong status or mask bit reaches `irq` and the masked-status word one edge after the event that corrupted it. A control word that accepted an illegal command leaves the counter in the wrong mode, and the next tick then moves a count that should have stayed put, or leaves still a count that should have moved.

// File: rtl/drt_pkg.sv
package drt_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  // offsets within one timer's window, and the window stride
  localparam int OFF_RELOAD = 'h00;
  localparam int OFF_COUNT  = 'h04;
  localparam int OFF_CTRL   = 'h08;
  localparam int TMR_STRIDE = 'h10;

  // shared interrupt words
  localparam int ADR_MASK  = 'h48;
  localparam int ADR_ACK   = 'h4C;
  localparam int ADR_RAW   = 'h50;
  localparam int ADR_MSTAT = 'h54;

  // tick source codes
  localparam int SRC_EXT       = 1;
  localparam int SRC_RATE_BASE = 4;

  typedef enum logic [1:0] {
    CMD_LOAD = 2'd0,
    CMD_HOLD = 2'd1,
    CMD_RUN  = 2'd2,
    CMD_BAD  = 2'd3
  } drt_cmd_e;
endpackage

// File: rtl/drt_timer.sv
module drt_timer
  import drt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SRC_W     = 3,
  parameter int NUM_RATES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reload_wr,
  input  logic                 ctrl_wr,
  input  logic [CNT_W-1:0]     wdata,
  input  logic [NUM_RATES-1:0] tick_rate,
  input  logic                 tick_ext,
  output logic [CNT_W-1:0]     count_o,
  output logic [CNT_W-1:0]     reload_o,
  output logic [SRC_W+1:0]     ctrl_o,
  output logic                 expire_o
);
  logic [CNT_W-1:0] count_q, reload_q;
  logic [SRC_W+1:0] ctrl_q;
  logic [SRC_W-1:0] src;
  drt_cmd_e         cmd_new;
  logic             ctrl_ok, running, tick_sel, at_end;

  assign cmd_new = drt_cmd_e'(wdata[1:0]);
  assign ctrl_ok = ctrl_wr && (cmd_new != CMD_BAD);
  assign src     = ctrl_q[SRC_W+1:2];
  assign running = (drt_cmd_e'(ctrl_q[1:0]) == CMD_RUN);
  assign at_end  = (count_q <= CNT_W'(1));

  always_comb begin
    tick_sel = 1'b0;
    if (src == SRC_W'(SRC_EXT)) tick_sel = tick_ext;
    for (int r = 0; r < NUM_RATES; r++) begin
      if (src == SRC_W'(SRC_RATE_BASE + r)) tick_sel = tick_rate[r];
    end
  end

  // a control write takes the edge; a tick in that cycle is dropped
  assign expire_o = running && tick_sel && at_end && !ctrl_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (reload_wr) reload_q <= wdata;
      if (ctrl_ok) begin
        ctrl_q <= wdata[SRC_W+1:0];
        if (cmd_new == CMD_LOAD) count_q <= reload_q;
      end else if (running && tick_sel) begin
        count_q <= at_end ? reload_q : count_q - CNT_W'(1);
      end
    end
  end

  assign count_o  = count_q;
  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/drt_irq_unit.sv
module drt_irq_unit #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit_i,
  input  logic         mask_wr,
  input  logic         ack_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] mask_q, status_q, clr_bits;

  assign clr_bits = ack_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (mask_wr) mask_q <= wdata;
      // new expiries are OR-ed in after the clear, so they win
      status_q <= (status_q & ~clr_bits) | hit_i;
    end
  end

  assign mask_o   = mask_q;
  assign status_o = status_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
  import drt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int SRC_W     = 3,
  parameter int NUM_RATES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_RATES-1:0] tick_rate,
  input  logic                 tick_ext,
  output logic                 irq
);
  localparam int NUM_TMR = 2;

  logic [CNT_W-1:0]   cnt_val    [NUM_TMR];
  logic [CNT_W-1:0]   reload_val [NUM_TMR];
  logic [SRC_W+1:0]   ctrl_val   [NUM_TMR];
  logic [NUM_TMR-1:0] hit_vec, raw_status, mask_q;
  logic               wr_cyc, rd_cyc, mask_wr, ack_wr;

  assign wr_cyc  = reg_en && reg_wr;
  assign rd_cyc  = reg_en && !reg_wr;
  assign mask_wr = wr_cyc && (reg_addr == ADDR_W'(ADR_MASK));
  assign ack_wr  = wr_cyc && (reg_addr == ADDR_W'(ADR_ACK));

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic rl_wr, ct_wr;
    assign rl_wr = wr_cyc && (reg_addr == ADDR_W'(t * TMR_STRIDE + OFF_RELOAD));
    assign ct_wr = wr_cyc && (reg_addr == ADDR_W'(t * TMR_STRIDE + OFF_CTRL));

    drt_timer #(
      .CNT_W(CNT_W), .SRC_W(SRC_W), .NUM_RATES(NUM_RATES)
    ) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .reload_wr (rl_wr),
      .ctrl_wr   (ct_wr),
      .wdata     (reg_wdata[CNT_W-1:0]),
      .tick_rate (tick_rate),
      .tick_ext  (tick_ext),
      .count_o   (cnt_val[t]),
      .reload_o  (reload_val[t]),
      .ctrl_o    (ctrl_val[t]),
      .expire_o  (hit_vec[t])
    );
  end

  drt_irq_unit #(.N(NUM_TMR)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit_vec),
    .mask_wr  (mask_wr),
    .ack_wr   (ack_wr),
    .wdata    (reg_wdata[NUM_TMR-1:0]),
    .mask_o   (mask_q),
    .status_o (raw_status),
    .irq_o    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (rd_cyc) begin
      for (int t = 0; t < NUM_TMR; t++) begin
        if (reg_addr == ADDR_W'(t * TMR_STRIDE + OFF_RELOAD)) reg_rdata = REG_W'(reload_val[t]);
        if (reg_addr == ADDR_W'(t * TMR_STRIDE + OFF_COUNT))  reg_rdata = REG_W'(cnt_val[t]);
        if (reg_addr == ADDR_W'(t * TMR_STRIDE + OFF_CTRL))   reg_rdata = REG_W'(ctrl_val[t]);
      end
      if (reg_addr == ADDR_W'(ADR_MASK))  reg_rdata = REG_W'(mask_q);
      if (reg_addr == ADDR_W'(ADR_RAW))   reg_rdata = REG_W'(raw_status);
      if (reg_addr == ADDR_W'(ADR_MSTAT)) reg_rdata = REG_W'(raw_status & mask_q);
    end
  end
endmodule

// File: rtl/drt_checker.sv
module drt_checker
  import drt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SRC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_en,
  input logic             reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic             irq,
  input logic [1:0]       hit,
  input logic [1:0]       status,
  input logic [CNT_W-1:0] count0,
  input logic [CNT_W-1:0] reload0,
  input logic [SRC_W+1:0] ctrl0
);
  logic w_ctrl0, w_reload0, w_mask, w_ack;
  assign w_ctrl0   = reg_en && reg_wr && reg_addr == ADDR_W'(OFF_CTRL);
  assign w_reload0 = reg_en && reg_wr && reg_addr == ADDR_W'(OFF_RELOAD);
  assign w_mask    = reg_en && reg_wr && reg_addr == ADDR_W'(ADR_MASK);
  assign w_ack     = reg_en && reg_wr && reg_addr == ADDR_W'(ADR_ACK);

  AST_HIT_SETS_BIT0: assert property (@(posedge clk) disable iff (!rst_n) hit[0] |=> status[0]); // R5
  AST_HIT_SETS_BIT1: assert property (@(posedge clk) disable iff (!rst_n) hit[1] |=> status[1]); // R5
  AST_REFILL_VALUE: assert property (@(posedge clk) disable iff (!rst_n) hit[0] |=> count0 == $past(reload0)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (w_ack && reg_wdata[0] && !hit[0]) |=> !status[0]); // R6
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (ctrl0[1:0] == 2'd1 && !w_ctrl0) |=> $stable(count0)); // R3
  AST_BAD_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (w_ctrl0 && reg_wdata[1:0] == 2'd3) |=> ($stable(ctrl0) && $stable(count0))); // R10
  AST_RELOAD_WR_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (w_reload0 && ctrl0[1:0] != 2'd2) |=> $stable(count0)); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> ($past(|hit) || $past(w_mask))); // R7
  AST_IRQ_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq) |-> ($past(w_ack) || $past(w_mask))); // R7
endmodule

bind dual_reload_timer drt_checker #(.CNT_W(CNT_W), .SRC_W(SRC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_en    (reg_en),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .hit       (hit_vec),
  .status    (raw_status),
  .count0    (cnt_val[0]),
  .reload0   (reload_val[0]),
  .ctrl0     (ctrl_val[0])
);

// File: tb/dual_reload_timer_test.sv
module dual_reload_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_en = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  tick_rate = '0;
  logic        tick_ext = 1'b0;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 0;

  dual_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_rate(tick_rate), .tick_ext(tick_ext), .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read-compare, 2 tick (data[3:0] rates, data[4] ext)
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 50;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'h00, 32'd3,        32'd0,    8'd2},  // R2 reload0 = 3
    '{2'd0, 8'h08, 32'h10,       32'd0,    8'd3},  // R3 src 4, load
    '{2'd1, 8'h04, 32'd0,        32'd3,    8'd3},  // R3 count loaded
    '{2'd1, 8'h08, 32'd0,        32'h10,   8'd2},  // R2 ctrl readback
    '{2'd0, 8'h08, 32'h12,       32'd0,    8'd4},  // R4 run
    '{2'd2, 8'h00, 32'h01,       32'd0,    8'd4},
    '{2'd1, 8'h04, 32'd0,        32'd2,    8'd4},  // R4 one step
    '{2'd0, 8'h00, 32'd5,        32'd0,    8'd9},  // R9 reload change while running
    '{2'd1, 8'h04, 32'd0,        32'd2,    8'd9},  // R9 count untouched
    '{2'd2, 8'h00, 32'h01,       32'd0,    8'd4},
    '{2'd2, 8'h00, 32'h01,       32'd0,    8'd5},
    '{2'd1, 8'h04, 32'd0,        32'd5,    8'd9},  // R9 refill uses new value
    '{2'd1, 8'h00, 32'd0,        32'd5,    8'd2},  // R2
    '{2'd1, 8'h50, 32'd0,        32'd1,    8'd5},  // R5 bit0 set
    '{2'd1, 8'h54, 32'd0,        32'd0,    8'd7},  // R7 masked off
    '{2'd0, 8'h48, 32'hFFFFFFFF, 32'd0,    8'd7},
    '{2'd1, 8'h48, 32'd0,        32'd3,    8'd2},  // R2 mask two bits
    '{2'd1, 8'h54, 32'd0,        32'd1,    8'd7},  // R7
    '{2'd0, 8'h4C, 32'd1,        32'd0,    8'd6},
    '{2'd1, 8'h50, 32'd0,        32'd0,    8'd6},  // R6 cleared
    '{2'd1, 8'h4C, 32'd0,        32'd0,    8'd6},  // R6 ack reads 0
    '{2'd0, 8'h10, 32'd2,        32'd0,    8'd2},
    '{2'd0, 8'h18, 32'h18,       32'd0,    8'd3},  // src 6, load
    '{2'd1, 8'h14, 32'd0,        32'd2,    8'd3},  // R3
    '{2'd0, 8'h18, 32'h1A,       32'd0,    8'd4},
    '{2'd2, 8'h00, 32'h01,       32'd0,    8'd4},
    '{2'd1, 8'h14, 32'd0,        32'd2,    8'd4},  // R4 other tick ignored
    '{2'd1, 8'h04, 32'd0,        32'd4,    8'd4},  // R4 timer0 moved
    '{2'd2, 8'h00, 32'h04,       32'd0,    8'd4},
    '{2'd1, 8'h14, 32'd0,        32'd1,    8'd4},  // R4
    '{2'd0, 8'h18, 32'h19,       32'd0,    8'd3},  // hold
    '{2'd2, 8'h00, 32'h04,       32'd0,    8'd3},
    '{2'd1, 8'h14, 32'd0,        32'd1,    8'd3},  // R3 frozen
    '{2'd0, 8'h18, 32'h1B,       32'd0,    8'd10}, // R10 illegal
    '{2'd1, 8'h18, 32'd0,        32'h19,   8'd10}, // R10
    '{2'd1, 8'h14, 32'd0,        32'd1,    8'd10}, // R10
    '{2'd0, 8'h20, 32'hFFFF,     32'd0,    8'd11},
    '{2'd1, 8'h20, 32'd0,        32'd0,    8'd11}, // R11
    '{2'd0, 8'h18, 32'h06,       32'd0,    8'd4},  // src 1 run
    '{2'd2, 8'h00, 32'h10,       32'd0,    8'd5},
    '{2'd1, 8'h14, 32'd0,        32'd2,    8'd5},  // R5 refill
    '{2'd1, 8'h50, 32'd0,        32'd2,    8'd5},  // R5 bit1
    '{2'd1, 8'h54, 32'd0,        32'd2,    8'd7},  // R7
    '{2'd0, 8'h48, 32'd0,        32'd0,    8'd7},
    '{2'd1, 8'h54, 32'd0,        32'd0,    8'd7},  // R7
    '{2'd0, 8'h4C, 32'd3,        32'd0,    8'd6},
    '{2'd1, 8'h50, 32'd0,        32'd0,    8'd6},  // R6
    '{2'd0, 8'h08, 32'h02,       32'd0,    8'd4},  // src 0 run
    '{2'd2, 8'h00, 32'h1F,       32'd0,    8'd4},
    '{2'd1, 8'h04, 32'd0,        32'd4,    8'd4}   // R4 no source, no step
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_en = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_en = 1; reg_wr = 0; reg_addr = a;
    #2 d = reg_rdata;
    reg_en = 0;
  endtask

  task automatic tick(input logic [4:0] m);
    @(posedge clk); #1;
    tick_rate = m[3:0]; tick_ext = m[4];
    @(posedge clk); #1;
    tick_rate = '0; tick_ext = 0;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // reset state, R1
    rchk("R1", 8'h00, 0); rchk("R1", 8'h04, 0); rchk("R1", 8'h08, 0);
    rchk("R1", 8'h48, 0); rchk("R1", 8'h50, 0); rchk("R1", 8'h54, 0);
    chk("R1", {31'd0, irq}, 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].data);
        2'd1: begin
          logic [31:0] v;
          rd(VEC[i].addr, v);
          chk($sformatf("R%0d (vector %0d)", VEC[i].req, i), v, VEC[i].exp);
        end
        default: tick(VEC[i].data[4:0]);
      endcase
    end

    // R8: expiry and acknowledge of bit 0 on the same edge
    wr(8'h00, 32'd1);
    wr(8'h08, 32'h10);
    wr(8'h08, 32'h12);
    wr(8'h48, 32'd1);
    @(posedge clk); #1;
    tick_rate = 4'h1; reg_en = 1; reg_wr = 1; reg_addr = 8'h4C; reg_wdata = 32'd1;
    @(posedge clk); #1;
    tick_rate = '0; reg_en = 0; reg_wr = 0;
    rchk("R8", 8'h50, 32'd1);
    chk("R7", {31'd0, irq}, 1);
    // R7: acknowledge drops irq at the write edge
    wr(8'h4C, 32'd1);
    chk("R7", {31'd0, irq}, 0);
    // R7: mask write raises irq at its edge
    tick(5'h01);
    wr(8'h48, 32'd0);
    chk("R7", {31'd0, irq}, 0);
    wr(8'h48, 32'd1);
    chk("R7", {31'd0, irq}, 1);

    // R1: reset in the middle of operation
    @(posedge clk); #1 rst_n = 0;
    #2 chk("R1", {31'd0, irq}, 0);
    @(posedge clk); #1 rst_n = 1;
    rchk("R1", 8'h04, 0); rchk("R1", 8'h50, 0); rchk("R1", 8'h48, 0);
    tick(5'h1F);
    rchk("R1", 8'h04, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule